// File: doc/BRIEF.md
# Compare Timer with Mode-Dependent Buffered Compare

This block is a free-running up-counter with a programmable wrap limit and one compare channel. A fixed prescaler divides the clock, and the counter advances by one on each prescaled tick. When the counter reaches the wrap limit, the next tick returns it to zero. Each time the count equals the active compare value on a tick, the block sets a sticky match flag. If interrupts are enabled, it also emits a one-cycle interrupt pulse.

There are two run modes, and they differ in how a new compare value is applied. In clear-on-compare mode, a compare write is applied directly and is used from the next cycle. In pulse-width mode, a compare write is held in a shadow register. That value is copied into the active compare only on the tick where the counter wraps, so every period uses one consistent compare value. Any other mode code holds the counter. Software reaches all state through a single-cycle register write port.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset, the count is 0, the match flag and interrupt output are 0, the mode code is 0 (stopped), the interrupt enable is 0, the wrap limit is 16'hFFFF, and both the shadow and active compare values are 0.
- R2: While `pre_en_i` is high, the prescaler produces one tick every 8 clocks, the first one on the 8th enabled clock. A running counter advances by one on each tick only. While `pre_en_i` is low, neither the prescaler phase nor the count changes.
- R3: On a tick in a run mode, the count goes to 0 if it equals the wrap limit. This holds in both run modes.
- R4: The mode code is written through select 2, data bits [3:0]. Code 4'b1100 is clear-on-compare mode and 4'b1101 is pulse-width mode. Data bit 4 of the same write is the interrupt enable. Any other mode code holds the count at its present value.
- R5: Write selects are: 0 for the wrap limit, 1 for the compare value, 2 for control, and 3 for flag clear. A write takes effect at the clock edge where `wr_en_i` is high.
- R6: When the mode is not pulse-width, a compare write updates both the shadow and the active compare value. A match against the new value can occur from the next cycle.
- R7: In pulse-width mode, a compare write goes only to the shadow register. The shadow is copied to the active compare on the tick where the counter wraps. A write made in the same cycle as that wrap tick is applied at the following wrap.
- R8: In pulse-width mode, when several compare writes land within one period, only the last one becomes active at the wrap.
- R9: On a tick in a run mode where the count equals the active compare, `match_flag_o` is 1 from the next cycle. It stays 1 until a select-3 write with data bit 0 set. A select-3 write with bit 0 clear has no effect, and a new match in the same cycle as a clear wins over the clear.
- R10: `irq_o` is high for exactly the cycle after a match tick, and only if the interrupt enable was 1 at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pre_en_i | input | 1 | Prescaler enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 wrap limit, 1 compare, 2 control, 3 flag clear) |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| match_flag_o | output | 1 | Sticky compare-match flag |
| irq_o | output | 1 | One-cycle match interrupt pulse |

## Verification
Internal faults in this block show up at the ports as timing errors, and they show up quickly. A prescaler phase that is off by one moves every count step, so `count_o` is wrong within 8 enabled clocks. A shadow register that is copied at the wrong time moves the match flag and interrupt by a whole period. A direct write that is wrongly buffered delays a match by one period as well. The bench keeps a tick-accurate model of the count, the shadow and active compare values and the flag, built from the requirements. It compares all three outputs on every cycle while sweeping compare writes across every phase of short periods, so any such slip is reported in the cycle it first becomes visible.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_CTC = 4'b1100;
    localparam logic [MODE_W-1:0] MODE_PWM = 4'b1101;

    typedef enum logic [1:0] {
        SEL_TOP  = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              irq_en;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic logic mode_runs(input logic [MODE_W-1:0] m);
        return (m == MODE_CTC) || (m == MODE_PWM);
    endfunction

    function automatic logic mode_buffers(input logic [MODE_W-1:0] m);
        return m == MODE_PWM;
    endfunction

endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
    parameter int DIV = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick_o = en_i;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            assign tick_o = en_i && (phase_q == LAST);

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    phase_q <= '0;
                end else if (en_i) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cmp_timer_cnt.sv
module cmp_timer_cnt #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    assign cnt_o  = cnt_q;
    assign wrap_o = step_i && (cnt_q == top_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= (cnt_q == top_i) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cmp_timer_cmp.sv
module cmp_timer_cmp #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         buffered_i,
    input  logic         wrap_i,
    input  logic         step_i,
    input  logic [W-1:0] cnt_i,
    input  logic         irq_en_i,
    input  logic         clr_i,
    output logic [W-1:0] act_o,
    output logic         flag_o,
    output logic         irq_o
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] act_q;
    logic         flag_q;
    logic         irq_q;
    logic         hit;

    assign hit    = step_i && (cnt_i == act_q);
    assign act_o  = act_q;
    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_i) begin
                shadow_q <= wdata_i;
            end
            if (wr_i && !buffered_i) begin
                act_q <= wdata_i;
            end else if (wrap_i && buffered_i) begin
                act_q <= shadow_q;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
            irq_q <= hit && irq_en_i;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRE_DIV = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pre_en_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_flag_o,
    output logic             irq_o
);
    reg_sel_e         sel;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] top_q;
    logic             tick;
    logic             run;
    logic             pwm;
    logic             step;
    logic             wrap;
    logic             cmp_wr;
    logic             clr;
    logic [CNT_W-1:0] act_cmp;

    assign sel    = reg_sel_e'(wr_sel_i);
    assign run    = mode_runs(ctrl_q.mode);
    assign pwm    = mode_buffers(ctrl_q.mode);
    assign step   = tick && run;
    assign cmp_wr = wr_en_i && (sel == SEL_CMP);
    assign clr    = wr_en_i && (sel == SEL_FLAG) && wr_data_i[0];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            top_q  <= '1;
            ctrl_q <= '0;
        end else if (wr_en_i) begin
            if (sel == SEL_TOP) begin
                top_q <= wr_data_i;
            end
            if (sel == SEL_CTRL) begin
                ctrl_q <= ctrl_t'(wr_data_i[MODE_W:0]);
            end
        end
    end

    cmp_timer_presc #(.DIV(PRE_DIV)) presc_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (pre_en_i),
        .tick_o(tick)
    );

    cmp_timer_cnt #(.W(CNT_W)) cnt_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(step),
        .top_i (top_q),
        .cnt_o (count_o),
        .wrap_o(wrap)
    );

    cmp_timer_cmp #(.W(CNT_W)) cmp_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (cmp_wr),
        .wdata_i   (wr_data_i),
        .buffered_i(pwm),
        .wrap_i    (wrap),
        .step_i    (step),
        .cnt_i     (count_o),
        .irq_en_i  (ctrl_q.irq_en),
        .clr_i     (clr),
        .act_o     (act_cmp),
        .flag_o    (match_flag_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         tick,
    input logic         run,
    input logic         pwm,
    input logic         wrap,
    input logic         clr,
    input logic [W-1:0] top_q,
    input logic [W-1:0] act_cmp,
    input logic [W-1:0] count_o,
    input logic         match_flag_o,
    input logic         irq_o
);
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick |=> $stable(count_o)); // R2

    AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !run |=> $stable(count_o)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick && run && count_o == top_q) |=> (count_o == '0)); // R3

    AST_PWM_ACT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwm && !wrap) |=> $stable(act_cmp)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_flag_o && !clr) |=> match_flag_o); // R9

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> match_flag_o); // R10
endmodule

bind cmp_timer cmp_timer_chk #(.W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick        (tick),
    .run         (run),
    .pwm         (pwm),
    .wrap        (wrap),
    .clr         (clr),
    .top_q       (top_q),
    .act_cmp     (act_cmp),
    .count_o     (count_o),
    .match_flag_o(match_flag_o),
    .irq_o       (irq_o)
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIVN = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        pre_en;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        flag;
    logic        irq;

    int    n_vec  = 0;
    int    n_bad  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string tag    = "R1";

    // reference state
    int          m_div = 0;
    logic [15:0] m_cnt = 0, m_top = 16'hFFFF, m_shadow = 0, m_act = 0;
    logic [3:0]  m_mode = 0;
    logic        m_ie = 0, m_flag = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .pre_en_i    (pre_en),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .count_o     (count),
        .match_flag_o(flag),
        .irq_o       (irq)
    );

    task automatic chk(input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cycles);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // model update from the inputs being driven for the coming edge
    task automatic model_step();
        logic tk, runm, pwmm, stp, hit, wr, wrp, clr_w;
        tk    = pre_en && (m_div == DIVN - 1);
        if (pre_en) m_div = (m_div == DIVN - 1) ? 0 : m_div + 1;
        runm  = (m_mode == 4'b1100) || (m_mode == 4'b1101);
        pwmm  = (m_mode == 4'b1101);
        stp   = tk && runm;
        hit   = stp && (m_cnt == m_act);
        wrp   = stp && (m_cnt == m_top);
        wr    = wr_en && (wr_sel == 2'd1);
        clr_w = wr_en && (wr_sel == 2'd3) && wr_data[0];
        m_irq = hit && m_ie;
        if (hit) m_flag = 1'b1;
        else if (clr_w) m_flag = 1'b0;
        if (wr && !pwmm) m_act = wr_data;
        else if (wrp && pwmm) m_act = m_shadow;
        if (wr) m_shadow = wr_data;
        if (stp) m_cnt = wrp ? 16'd0 : m_cnt + 16'd1;
        if (wr_en && wr_sel == 2'd0) m_top = wr_data;
        if (wr_en && wr_sel == 2'd2) begin
            m_mode = wr_data[3:0];
            m_ie   = wr_data[4];
        end
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        cycles++;
        chk("count", count, m_cnt);
        chk("flag", flag, m_flag);
        chk("irq", irq, m_irq);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired got 0 expected 1");
        summary();
    end

    initial begin
        rst = 1; pre_en = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1 reset";
        chk("count", count, 0);
        chk("flag", flag, 0);
        chk("irq", irq, 0);

        // R4: stopped codes hold the counter; R5: select decode
        tag = "R4 stopped mode";
        pre_en = 1;
        idle(40);
        tag = "R5 top write";
        wr(2'd0, 16'd9);
        tag = "R4 invalid code";
        wr(2'd2, 16'h0016);
        idle(30);
        tag = "R6 direct while stopped";
        wr(2'd1, 16'd4);
        idle(10);

        // R2/R3: clear-on-compare run, wrap at limit, prescale gating
        tag = "R3 ctc wrap";
        wr(2'd2, 16'h001C);
        idle(200);
        tag = "R2 prescale gated";
        pre_en = 0;
        idle(30);
        pre_en = 1;
        idle(50);

        // R6: direct compare write in clear-on-compare mode
        tag = "R6 ctc direct";
        for (int k = 0; k < 30; k++) begin
            wr(2'd1, 16'(k % 11));
            idle(k % 9);
        end
        idle(90);

        // R9: clear behaviour
        tag = "R9 clear bit0 zero";
        wr(2'd3, 16'h0002);
        idle(3);
        tag = "R9 clear";
        wr(2'd3, 16'h0001);
        idle(3);
        tag = "R9 clear sweep";
        for (int k = 0; k < 24; k++) begin
            wr(2'd3, 16'h0001);
            idle(k % 8);
        end

        // R10: interrupt disabled
        tag = "R10 irq disabled";
        wr(2'd2, 16'h000C);
        idle(120);
        tag = "R10 irq enabled";
        wr(2'd2, 16'h001C);
        idle(120);

        // R7: buffered writes in pulse-width mode, every phase
        tag = "R7 pwm buffered";
        wr(2'd2, 16'h001D);
        idle(40);
        wr(2'd1, 16'd2);
        idle(100);
        for (int k = 0; k < 90; k++) begin
            wr(2'd1, 16'(k % 10));
            idle(k % 13);
        end
        idle(100);

        // R8: several writes in one period
        tag = "R8 last write wins";
        wr(2'd1, 16'd1);
        wr(2'd1, 16'd8);
        idle(100);
        wr(2'd1, 16'd3);
        idle(20);
        wr(2'd1, 16'd6);
        idle(100);

        // short periods in both modes
        for (int t = 0; t < 4; t++) begin
            for (int m = 0; m < 2; m++) begin
                tag = (m == 0) ? "R3 short ctc" : "R7 short pwm";
                wr(2'd0, 16'(t));
                wr(2'd2, m == 0 ? 16'h001C : 16'h001D);
                for (int c = 0; c <= t + 1; c++) begin
                    wr(2'd1, 16'(c));
                    idle(8 * (t + 2));
                    wr(2'd3, 16'h0001);
                end
            end
        end

        summary();
    end
endmodule